// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Output Unit

This block is one channel of a free-running timer. It holds a 16-bit channel register and works in one of two modes. In compare mode the register is matched against the shared timer count. Each match raises the interrupt flag and drives an output bit through an eight-way output-mode table. The table responds to two events: the channel's own match, and the period event that channel 0 broadcasts when the count reaches the period value. This lets the channel produce PWM with no software involvement.

In capture mode an external input first passes through a synchroniser. A selected edge of that input then loads the current timer count into the channel register and raises the interrupt flag. If the flag was still pending at the time of a capture, a capture-overflow flag is also raised.

The timer count, the count-advance strobe and the period event all come from the shared timer. Software writes the channel register, selects the mode, chooses the edge and output mode, supplies the bit used by the pass-through output mode, and clears the flags.

Top module: `ccp_channel`

## Requirements
- R1: After a synchronous active-low reset, `out_bit`, `irq_flag` and `ovf_flag` are 0 and `ccr_q` is 0.
- R2: When `ccr_we` is high, `ccr_q` takes `ccr_wdata` on the next clock edge. A write has priority over a capture in the same cycle.
- R3: In compare mode (`cap_mode`=0), a cycle with `cnt_step`=1 and `tmr_cnt`=`ccr_q` is an own match. It sets `irq_flag` at the next edge. `irq_clr` clears `irq_flag` and `ovf_flag`, and a set in the same cycle wins over the clear.
- R4: Single-action values of `out_mode` (all register at the next edge): 0 makes `out_bit` follow `sw_out`; 1 sets it on an own match; 4 toggles it on an own match; 5 clears it on an own match. In these four modes the period event `per_evt` has no effect.
- R5: Two-action values of `out_mode`: 2 = toggle on own match and clear on period; 3 = set on own match and clear on period; 6 = toggle on own match and set on period; 7 = clear on own match and set on period.
- R6: When the own match and `per_evt` occur in the same cycle, the period action is applied after the own action. Modes 2 and 3 therefore end at 0, and modes 6 and 7 end at 1.
- R7: With mode 7, a count wrapping 0..999 with `per_evt` at 999, and `ccr_q`=99, `out_bit` is high for exactly 100 of every 1000 ticks.
- R8: In capture mode, `cap_in` passes through two synchroniser flops and an edge register. `ccr_q` loads the `tmr_cnt` value present at the third rising clock edge after `cap_in` changes. `irq_flag` is set at that same edge.
- R9: `cap_edge` encoding: 0 = no capture, 1 = rising edges, 2 = falling edges, 3 = both edges.
- R10: A capture while `irq_flag` is already 1 sets `ovf_flag`. A capture while `irq_flag` is 0 leaves `ovf_flag` unchanged.
- R11: In capture mode no own match occurs and `per_evt` is ignored. `out_bit` holds its value unless `out_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_cnt | input | 16 | Shared timer count |
| cnt_step | input | 1 | Count holds a freshly reached value this cycle |
| per_evt | input | 1 | Channel-0 period match event |
| cap_mode | input | 1 | 1 = capture mode, 0 = compare mode |
| cap_edge | input | 2 | Capture edge select |
| out_mode | input | 3 | Output-mode table select |
| sw_out | input | 1 | Output value used by mode 0 |
| cap_in | input | 1 | Asynchronous capture input |
| ccr_we | input | 1 | Channel register write strobe |
| ccr_wdata | input | 16 | Channel register write data |
| irq_clr | input | 1 | Clear interrupt and overflow flags |
| out_bit | output | 1 | Output bit |
| irq_flag | output | 1 | Interrupt flag |
| ovf_flag | output | 1 | Capture overflow flag |
| ccr_q | output | 16 | Channel register (compare value or captured count) |

## Verification
Register writes, compare flags and output-table updates all appear one edge after the cycle that causes them. The bench drives its inputs just after a falling edge, lets one rising edge pass, and compares at the next falling edge against a model advanced by one step. Captures appear three rising edges after `cap_in` moves. The capture sequences therefore advance the count by one per cycle and expect the value present before that third edge. The PWM case counts high samples over a whole 1000-tick window after the first period has settled.

// File: rtl/ccp_pkg.sv
// Shared types for the capture/compare channel.
// Assumes: encodings below are software-visible and must not be reordered.
package ccp_pkg;
    typedef enum logic [2:0] {
        OM_SOFT    = 3'd0,
        OM_SET     = 3'd1,
        OM_TGL_RST = 3'd2,
        OM_SET_RST = 3'd3,
        OM_TGL     = 3'd4,
        OM_RST     = 3'd5,
        OM_TGL_SET = 3'd6,
        OM_RST_SET = 3'd7
    } out_mode_t;

    typedef enum logic [1:0] {
        EDG_NONE = 2'd0,
        EDG_RISE = 2'd1,
        EDG_FALL = 2'd2,
        EDG_BOTH = 2'd3
    } edge_sel_t;
endpackage

// File: rtl/ccp_cap_edge.sv
// Synchronises the asynchronous capture input and emits a one-cycle pulse
// on the selected edge(s).
// Assumes: cap_in may change at any time; SYNC_STAGES >= 2.
module ccp_cap_edge
    import ccp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cap_in,
    input  edge_sel_t edge_sel,
    output logic      cap_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise, fall;

    // Shift the input through the synchroniser chain.
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n)      sync_q[s] <= 1'b0;
                else if (s == 0) sync_q[s] <= cap_in;
                else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Decode the edge and apply the selection.
    always_comb begin
        rise = sync_q[SYNC_STAGES-1] & ~prev_q;
        fall = ~sync_q[SYNC_STAGES-1] & prev_q;
        unique case (edge_sel)
            EDG_NONE: cap_evt = 1'b0;
            EDG_RISE: cap_evt = rise;
            EDG_FALL: cap_evt = fall;
            default:  cap_evt = rise | fall;
        endcase
    end
endmodule

// File: rtl/ccp_out_unit.sv
// Output bit state table: applies the own-match action first, then the
// period action, registered on the next edge.
// Assumes: own_evt and per_evt are single-cycle qualified events.
module ccp_out_unit
    import ccp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  out_mode_t mode,
    input  logic      sw_bit,
    input  logic      own_evt,
    input  logic      per_evt,
    output logic      out_q
);
    logic nxt;

    // Next output value from mode and events (own first, period last).
    always_comb begin
        nxt = out_q;
        unique case (mode)
            OM_SOFT:    nxt = sw_bit;
            OM_SET:     if (own_evt) nxt = 1'b1;
            OM_RST:     if (own_evt) nxt = 1'b0;
            OM_TGL:     if (own_evt) nxt = ~out_q;
            OM_TGL_RST: begin
                if (own_evt) nxt = ~out_q;
                if (per_evt) nxt = 1'b0;
            end
            OM_SET_RST: begin
                if (own_evt) nxt = 1'b1;
                if (per_evt) nxt = 1'b0;
            end
            OM_TGL_SET: begin
                if (own_evt) nxt = ~out_q;
                if (per_evt) nxt = 1'b1;
            end
            default: begin
                if (own_evt) nxt = 1'b0;
                if (per_evt) nxt = 1'b1;
            end
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= nxt;
    end

    AST_SET_MODE:   assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_SET && own_evt) |=> out_q);                       // R4
    AST_RST_MODE:   assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_RST && own_evt) |=> !out_q);                      // R4
    AST_PER_LAST_HI: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == OM_RST_SET || mode == OM_TGL_SET) && per_evt) |=> out_q);  // R6
    AST_PER_LAST_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == OM_SET_RST || mode == OM_TGL_RST) && per_evt) |=> !out_q); // R6
endmodule

// File: rtl/ccp_channel.sv
// One capture/compare timer channel: compare match against the shared
// count driving an output table, or synchronised edge capture of the count.
// Assumes: tmr_cnt, cnt_step and per_evt come from the shared timer core
// in this clock domain; cap_in is asynchronous.
module ccp_channel
    import ccp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tmr_cnt,
    input  logic             cnt_step,
    input  logic             per_evt,
    input  logic             cap_mode,
    input  logic [1:0]       cap_edge,
    input  logic [2:0]       out_mode,
    input  logic             sw_out,
    input  logic             cap_in,
    input  logic             ccr_we,
    input  logic [CNT_W-1:0] ccr_wdata,
    input  logic             irq_clr,
    output logic             out_bit,
    output logic             irq_flag,
    output logic             ovf_flag,
    output logic [CNT_W-1:0] ccr_q
);
    logic cap_evt;
    logic own_evt;
    logic per_q;
    logic cap_fire;

    ccp_cap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_in   (cap_in),
        .edge_sel (edge_sel_t'(cap_edge)),
        .cap_evt  (cap_evt)
    );

    // Qualify events by mode.
    always_comb begin
        own_evt  = !cap_mode && cnt_step && (tmr_cnt == ccr_q);
        per_q    = !cap_mode && per_evt;
        cap_fire = cap_mode && cap_evt;
    end

    ccp_out_unit u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (out_mode_t'(out_mode)),
        .sw_bit  (sw_out),
        .own_evt (own_evt),
        .per_evt (per_q),
        .out_q   (out_bit)
    );

    // Channel register: software write wins over capture.
    always_ff @(posedge clk) begin
        if (!rst_n)        ccr_q <= '0;
        else if (ccr_we)   ccr_q <= ccr_wdata;
        else if (cap_fire) ccr_q <= tmr_cnt;
    end

    // Interrupt flag: set by match or capture, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  irq_flag <= 1'b0;
        else if (own_evt || cap_fire) irq_flag <= 1'b1;
        else if (irq_clr)            irq_flag <= 1'b0;
    end

    // Overflow flag: capture while a previous one is still pending.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ovf_flag <= 1'b0;
        else if (cap_fire && irq_flag)  ovf_flag <= 1'b1;
        else if (irq_clr)               ovf_flag <= 1'b0;
    end

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_we |=> ccr_q == $past(ccr_wdata));                          // R2
    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode && cnt_step && tmr_cnt == ccr_q) |=> irq_flag);      // R3
    AST_CAP_LOAD:   assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && !ccr_we) |=> (ccr_q == $past(tmr_cnt)) && irq_flag); // R8
    AST_CAP_OVF:    assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && irq_flag) |=> ovf_flag);                           // R10
    AST_CAP_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && out_mode != 3'd0) |=> $stable(out_bit));           // R11
endmodule

// File: tb/sim_ccp_channel.sv
module sim_ccp_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmr_cnt = '0;
    logic        cnt_step = 1'b0, per_evt = 1'b0, cap_mode = 1'b0;
    logic [1:0]  cap_edge = 2'd0;
    logic [2:0]  out_mode = 3'd0;
    logic        sw_out = 1'b0, cap_in = 1'b0, ccr_we = 1'b0, irq_clr = 1'b0;
    logic [15:0] ccr_wdata = '0;
    logic        out_bit, irq_flag, ovf_flag;
    logic [15:0] ccr_q;

    int n_chk = 0, n_bad = 0, cycles = 0;

    ccp_channel u0 (
        .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .cnt_step(cnt_step),
        .per_evt(per_evt), .cap_mode(cap_mode), .cap_edge(cap_edge),
        .out_mode(out_mode), .sw_out(sw_out), .cap_in(cap_in),
        .ccr_we(ccr_we), .ccr_wdata(ccr_wdata), .irq_clr(irq_clr),
        .out_bit(out_bit), .irq_flag(irq_flag), .ovf_flag(ovf_flag),
        .ccr_q(ccr_q)
    );

    always #10 clk = ~clk;  // 50 MHz

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expected output from the mode table: own action, then period action.
    function automatic logic ref_out(input logic [2:0] m, input logic cur,
                                     input logic own, input logic per,
                                     input logic sw);
        logic v;
        v = cur;
        case (m)
            3'd0: v = sw;
            3'd1: if (own) v = 1'b1;
            3'd4: if (own) v = ~cur;
            3'd5: if (own) v = 1'b0;
            3'd2: begin if (own) v = ~cur; if (per) v = 1'b0; end
            3'd3: begin if (own) v = 1'b1; if (per) v = 1'b0; end
            3'd6: begin if (own) v = ~cur; if (per) v = 1'b1; end
            default: begin if (own) v = 1'b0; if (per) v = 1'b1; end
        endcase
        return v;
    endfunction

    task automatic wr_ccr(input logic [15:0] v);
        ccr_wdata = v; ccr_we = 1'b1;
        cyc();
        ccr_we = 1'b0;
    endtask

    task automatic clr_flags();
        irq_clr = 1'b1; cyc(); irq_clr = 1'b0;
    endtask

    // Change cap_in with the count stepping by one per cycle; returns after
    // the third edge, when the capture is due.
    task automatic cap_seq(input logic lvl, input logic [15:0] base);
        tmr_cnt = base; cap_in = lvl; cyc();
        tmr_cnt = base + 16'd1; cyc();
        tmr_cnt = base + 16'd2; cyc();
    endtask

    initial begin
        logic exp_out, exp_irq, own;
        int   hi;
        void'($urandom(32'd20240611));
        @(negedge clk);
        cyc(); cyc();
        chk("R1 out", out_bit, 0);
        chk("R1 irq", irq_flag, 0);
        chk("R1 ovf", ovf_flag, 0);
        chk("R1 ccr", ccr_q, 0);
        rst_n = 1'b1;
        cyc();

        // R2 register write
        wr_ccr(16'hA5C3);
        chk("R2 write", ccr_q, 16'hA5C3);

        // R3 compare flag, set wins over clear
        out_mode = 3'd1;
        tmr_cnt = 16'hA5C3; cnt_step = 1'b1; cyc(); cnt_step = 1'b0;
        chk("R3 irq on match", irq_flag, 1);
        chk("R4 set mode", out_bit, 1);
        clr_flags();
        chk("R3 irq cleared", irq_flag, 0);
        cnt_step = 1'b1; irq_clr = 1'b1; cyc(); cnt_step = 1'b0; irq_clr = 1'b0;
        chk("R3 set beats clear", irq_flag, 1);
        clr_flags();
        cnt_step = 1'b0; tmr_cnt = 16'hA5C3; cyc();
        chk("R3 no step no flag", irq_flag, 0);

        // R4 period event ignored in single-action modes
        out_mode = 3'd5; per_evt = 1'b1; cyc(); per_evt = 1'b0;
        chk("R4 reset mode ignores period", out_bit, 1);

        // R6 directed same-tick cases
        wr_ccr(16'd5);
        out_mode = 3'd3; tmr_cnt = 16'd5; cnt_step = 1'b1; per_evt = 1'b1; cyc();
        chk("R6 set/reset both -> 0", out_bit, 0);
        out_mode = 3'd6; cyc();
        chk("R6 toggle/set both -> 1", out_bit, 1);
        out_mode = 3'd2; cyc();
        chk("R6 toggle/reset both -> 0", out_bit, 0);
        out_mode = 3'd7; cyc();
        chk("R6 reset/set both -> 1", out_bit, 1);
        cnt_step = 1'b0; per_evt = 1'b0;
        clr_flags();

        // R4 R5 random compare-mode traffic against the model
        wr_ccr(16'd2);
        exp_out = out_bit; exp_irq = irq_flag;
        for (int i = 0; i < 600; i++) begin
            out_mode = 3'($urandom % 8);
            sw_out   = 1'($urandom % 2);
            cnt_step = 1'($urandom % 2);
            tmr_cnt  = 16'($urandom % 4);
            per_evt  = (($urandom % 3) == 0);
            irq_clr  = (($urandom % 5) == 0);
            own = cnt_step && (tmr_cnt == 16'd2);
            exp_out = ref_out(out_mode, exp_out, own, per_evt, sw_out);
            exp_irq = own ? 1'b1 : (irq_clr ? 1'b0 : exp_irq);
            cyc();
            chk("R5 random out", out_bit, exp_out);
            chk("R3 random irq", irq_flag, exp_irq);
        end
        cnt_step = 1'b0; per_evt = 1'b0; irq_clr = 1'b0;

        // R7 PWM 100/900
        wr_ccr(16'd99);
        out_mode = 3'd7; cnt_step = 1'b1; hi = 0;
        for (int c = 0; c < 2000; c++) begin
            tmr_cnt = 16'(c % 1000);
            per_evt = ((c % 1000) == 999);
            cyc();
            if (c >= 1000 && out_bit) hi++;
        end
        chk("R7 high ticks per period", hi, 100);
        cnt_step = 1'b0; per_evt = 1'b0;

        // R8 R9 capture
        cap_mode = 1'b1; cap_edge = 2'd1; out_mode = 3'd1;
        clr_flags();
        cyc(); cyc(); cyc();
        cap_seq(1'b1, 16'd100);
        chk("R8 capture value", ccr_q, 102);
        chk("R8 capture irq", irq_flag, 1);
        chk("R10 first capture no ovf", ovf_flag, 0);
        cap_seq(1'b0, 16'd200);
        chk("R9 rising select ignores fall", ccr_q, 102);
        cap_seq(1'b1, 16'd300);
        chk("R10 overflow on pending capture", ovf_flag, 1);
        chk("R8 second capture", ccr_q, 302);
        clr_flags();
        chk("R10 ovf cleared", ovf_flag, 0);
        cap_edge = 2'd2;
        cap_seq(1'b0, 16'd400);
        chk("R9 falling select", ccr_q, 402);
        cap_edge = 2'd0; clr_flags();
        cap_seq(1'b1, 16'd500);
        chk("R9 none select value", ccr_q, 402);
        chk("R9 none select irq", irq_flag, 0);
        cap_edge = 2'd3;
        cap_seq(1'b0, 16'd600);
        chk("R9 both select fall", ccr_q, 602);
        cap_seq(1'b1, 16'd700);
        chk("R9 both select rise", ccr_q, 702);
        // R2 write beats capture in the same cycle
        clr_flags();
        tmr_cnt = 16'd800; cap_in = 1'b0; cyc(); cyc();
        ccr_wdata = 16'd77; ccr_we = 1'b1; cyc(); ccr_we = 1'b0;
        chk("R2 write beats capture", ccr_q, 77);

        // R11 capture mode: no match, period ignored
        clr_flags();
        out_mode = 3'd3; cap_edge = 2'd0;
        tmr_cnt = 16'd77; cnt_step = 1'b1; per_evt = 1'b1;
        hi = out_bit;
        cyc(); cyc();
        chk("R11 out holds", out_bit, hi);
        chk("R11 no match flag", irq_flag, 0);
        out_mode = 3'd0; sw_out = ~out_bit; hi = sw_out; cyc();
        chk("R11 mode 0 still follows sw", out_bit, hi);
        cnt_step = 1'b0; per_evt = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule